// File: doc/BRIEF.md
# Cascaded Sinc Decimation Filter

This block turns the sample stream of a delta-sigma modulator into output words at a selectable word rate. A fifth-order sinc stage with a fixed ratio first brings the stream down to a base word rate. A third-order sinc stage then divides that base rate by a power-of-two ratio D. Both stages are cascaded moving-sum (CIC) structures, so the combined response is linear phase. A family bit selects one of two base rates whose ratio is 6:5. It does this by picking one of two fifth-order ratios, by default 10 and 12 modulator samples per base word. At the top rate of either family the third-order stage is bypassed and each base word goes straight to the output.

Rate code and family are captured only on a start pulse. That pulse also clears the state of both stages. The words the stages produce while they fill are then withheld, so every word flagged valid comes from a full window. The third-order stage gain D³ is removed exactly by an arithmetic shift. The fifth-order gain R⁵ is left in the output, because R is not a power of two.

Top module: `sinc_cascade_decim`

## Requirements
- R1: After reset the output valid is low, and the block runs with rate code 0 and family 0 until the first start pulse.
- R2: With family bit 0 the fifth-order stage emits one word per 10 accepted samples (parameter RATE_F0). With family bit 1 it emits one word per 12 (RATE_F1). Each word is five cascaded moving sums of that length, taken at every R-th accepted sample.
- R3: A rate code k from 1 to 9 enables the third-order stage with D = 2^k. Each output is three cascaded length-D moving sums of the base words, taken at every D-th word and shifted right arithmetically by 3·k bits.
- R4: Rate code 0 bypasses the third-order stage, and each settled base word is output unchanged.
- R5: A rate code above 9 (MAX_LOG2D) behaves as code 9.
- R6: The rate code and family inputs are sampled only in a cycle with start high. Changing them at any other time has no effect on the output.
- R7: Start clears all filter state, and any sample presented in the start cycle is ignored.
- R8: After reset or start, the first 3 third-order words are withheld (the first 4 base words in bypass), and every later word is flagged valid.
- R9: For a constant input x, each valid output equals x·R⁵ at every rate code.
- R10: With a sample accepted every cycle, valid outputs are R·D cycles apart (R in bypass), and the output valid is never high in two consecutive cycles.
- R11: Cycles with x_valid low do not advance the filter, whatever x_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous start: clears state and captures rate code and family |
| rate_sel | input | CODE_W (4) | Rate code: 0 = bypass, k = decimate by 2^k |
| fam_sel | input | 1 | Base-rate family: 0 → ratio RATE_F0, 1 → ratio RATE_F1 |
| x_valid | input | 1 | Modulator sample strobe |
| x_data | input | IN_W (4) | Signed modulator sample |
| y_valid | output | 1 | Output word strobe |
| y_data | output | OUT_W (24) | Signed output word |

## Verification
A constant input is applied at a short rate, a long rate and an out-of-range code. The output must equal x·R⁵ at each of them, which separates the gain handling of the bypass path from that of the shifted third-order path. An isolated impulse checks the shape and phase of the cascaded windows against a moving-sum model: an off-by-one in the decimation phase or the comb chain shifts or smears the response. Random samples, with and without gaps in the strobe, show whether idle cycles advance the filter. Random changes to the rate inputs between start pulses show whether the configuration leaks in outside a start. Measured output spacing shows whether the right ratio was selected, including the clamped code.

// File: rtl/sincd_pkg.sv
package sincd_pkg;
    localparam int FRONT_ORDER = 5;
    localparam int BACK_ORDER  = 3;
    localparam int SKIP_BACK   = 3;
    localparam int SKIP_FRONT  = 4;

    typedef enum logic {
        SRC_BACK  = 1'b0,
        SRC_FRONT = 1'b1
    } src_e;
endpackage

// File: rtl/sincd_cic.sv
module sincd_cic #(
    parameter int ORDER = 3,
    parameter int IN_W  = 8,
    parameter int ACC_W = 32,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [CNT_W-1:0]        ratio_m1,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_data
);
    typedef struct {
        logic signed [ACC_W-1:0] integ [ORDER];
        logic signed [ACC_W-1:0] dly   [ORDER];
        logic [CNT_W-1:0]        cnt;
        logic                    vld;
        logic signed [ACC_W-1:0] dat;
    } cic_st_t;

    cic_st_t st_d, st_q;

    always_comb begin : cic_next
        logic signed [ACC_W-1:0] tap;
        tap      = '0;
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            for (int i = 0; i < ORDER; i++) begin
                st_d.integ[i] = '0;
                st_d.dly[i]   = '0;
            end
            st_d.cnt = '0;
            st_d.dat = '0;
        end else if (in_valid) begin
            // integrators chained on the freshly updated value: no extra delay
            st_d.integ[0] = st_q.integ[0] + ACC_W'(in_data);
            for (int i = 1; i < ORDER; i++) begin
                st_d.integ[i] = st_q.integ[i] + st_d.integ[i-1];
            end
            if (st_q.cnt == ratio_m1) begin
                st_d.cnt = '0;
                tap      = st_d.integ[ORDER-1];
                for (int i = 0; i < ORDER; i++) begin
                    st_d.dly[i] = tap;
                    tap         = tap - st_q.dly[i];
                end
                st_d.vld = 1'b1;
                st_d.dat = tap;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ORDER; i++) begin
                st_q.integ[i] <= '0;
                st_q.dly[i]   <= '0;
            end
            st_q.cnt <= '0;
            st_q.vld <= 1'b0;
            st_q.dat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    AST_CIC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && ratio_m1 != '0) |=> !st_q.vld)
        else $error("decimated word on consecutive cycles"); // R10
    AST_CIC_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= ratio_m1)
        else $error("phase counter beyond ratio"); // R2
endmodule

// File: rtl/sincd_rate_ctrl.sv
module sincd_rate_ctrl #(
    parameter int MAX_LOG2D = 9,
    parameter int CODE_W    = 4,
    parameter int RATE_F0   = 10,
    parameter int RATE_F1   = 12,
    parameter int FCNT_W    = 4,
    parameter int BCNT_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              fam_sel,
    output logic [CODE_W-1:0] log2d,
    output logic              bypass,
    output logic [FCNT_W-1:0] front_rm1,
    output logic [BCNT_W-1:0] back_rm1
);
    typedef struct packed {
        logic              fam;
        logic [CODE_W-1:0] code;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.fam  = fam_sel;
            cfg_d.code = (rate_sel > CODE_W'(MAX_LOG2D)) ? CODE_W'(MAX_LOG2D) : rate_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign log2d     = cfg_q.code;
    assign bypass    = (cfg_q.code == '0);
    assign front_rm1 = cfg_q.fam ? FCNT_W'(RATE_F1 - 1) : FCNT_W'(RATE_F0 - 1);
    assign back_rm1  = BCNT_W'((32'd1 << cfg_q.code) - 32'd1);

    AST_CODE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.code <= CODE_W'(MAX_LOG2D))
        else $error("rate code above limit"); // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cfg_q))
        else $error("configuration moved without start"); // R6
endmodule

// File: rtl/sincd_out_stage.sv
module sincd_out_stage
    import sincd_pkg::*;
#(
    parameter int FRONT_W = 24,
    parameter int BACK_W  = 51,
    parameter int OUT_W   = 24,
    parameter int CODE_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      bypass,
    input  logic [CODE_W-1:0]         log2d,
    input  logic                      front_valid,
    input  logic signed [FRONT_W-1:0] front_data,
    input  logic                      back_valid,
    input  logic signed [BACK_W-1:0]  back_data,
    output logic                      y_valid,
    output logic signed [OUT_W-1:0]   y_data
);
    typedef struct packed {
        logic [2:0]              cnt;
        logic                    vld;
        logic signed [OUT_W-1:0] dat;
    } out_st_t;

    out_st_t st_d, st_q;
    src_e    src;
    logic    word_vld;
    logic [2:0] skip_lim;
    logic [CODE_W+1:0] shamt;
    logic signed [OUT_W-1:0] word;

    always_comb begin
        src   = bypass ? SRC_FRONT : SRC_BACK;
        shamt = {2'b00, log2d} + {1'b0, log2d, 1'b0};
        case (src)
            SRC_FRONT: begin
                word_vld = front_valid;
                skip_lim = 3'(SKIP_FRONT);
                word     = OUT_W'(front_data);
            end
            default: begin
                word_vld = back_valid;
                skip_lim = 3'(SKIP_BACK);
                word     = OUT_W'(back_data >>> shamt);
            end
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (word_vld) begin
            if (st_q.cnt == skip_lim) begin
                st_d.vld = 1'b1;
                st_d.dat = word;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_valid = st_q.vld;
    assign y_data  = st_q.dat;
endmodule

// File: rtl/sinc_cascade_decim.sv
module sinc_cascade_decim
    import sincd_pkg::*;
#(
    parameter int IN_W      = 4,
    parameter int RATE_F0   = 10,
    parameter int RATE_F1   = 12,
    parameter int MAX_LOG2D = 9,
    localparam int FRONT_RMAX = (RATE_F0 > RATE_F1) ? RATE_F0 : RATE_F1,
    localparam int FRONT_W    = IN_W + FRONT_ORDER * $clog2(FRONT_RMAX),
    localparam int BACK_W     = FRONT_W + BACK_ORDER * MAX_LOG2D,
    localparam int OUT_W      = FRONT_W,
    localparam int CODE_W     = $clog2(MAX_LOG2D + 1),
    localparam int FCNT_W     = $clog2(FRONT_RMAX),
    localparam int BCNT_W     = MAX_LOG2D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CODE_W-1:0]       rate_sel,
    input  logic                    fam_sel,
    input  logic                    x_valid,
    input  logic signed [IN_W-1:0]  x_data,
    output logic                    y_valid,
    output logic signed [OUT_W-1:0] y_data
);
    logic [CODE_W-1:0]         log2d;
    logic                      bypass;
    logic [FCNT_W-1:0]         front_rm1;
    logic [BCNT_W-1:0]         back_rm1;
    logic                      front_vld;
    logic signed [FRONT_W-1:0] front_dat;
    logic                      back_vld;
    logic signed [BACK_W-1:0]  back_dat;

    sincd_rate_ctrl #(
        .MAX_LOG2D(MAX_LOG2D), .CODE_W(CODE_W), .RATE_F0(RATE_F0),
        .RATE_F1(RATE_F1), .FCNT_W(FCNT_W), .BCNT_W(BCNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
        .fam_sel(fam_sel), .log2d(log2d), .bypass(bypass),
        .front_rm1(front_rm1), .back_rm1(back_rm1)
    );

    sincd_cic #(
        .ORDER(FRONT_ORDER), .IN_W(IN_W), .ACC_W(FRONT_W), .CNT_W(FCNT_W)
    ) u_front (
        .clk(clk), .rst_n(rst_n), .clr(start), .ratio_m1(front_rm1),
        .in_valid(x_valid), .in_data(x_data),
        .out_valid(front_vld), .out_data(front_dat)
    );

    sincd_cic #(
        .ORDER(BACK_ORDER), .IN_W(FRONT_W), .ACC_W(BACK_W), .CNT_W(BCNT_W)
    ) u_back (
        .clk(clk), .rst_n(rst_n), .clr(start), .ratio_m1(back_rm1),
        .in_valid(front_vld && !bypass), .in_data(front_dat),
        .out_valid(back_vld), .out_data(back_dat)
    );

    sincd_out_stage #(
        .FRONT_W(FRONT_W), .BACK_W(BACK_W), .OUT_W(OUT_W), .CODE_W(CODE_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .clr(start), .bypass(bypass), .log2d(log2d),
        .front_valid(front_vld), .front_data(front_dat),
        .back_valid(back_vld), .back_data(back_dat),
        .y_valid(y_valid), .y_data(y_data)
    );

    AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !back_vld)
        else $error("third-order stage active in bypass"); // R4
    AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid)
        else $error("output valid on consecutive cycles"); // R10
endmodule

// File: tb/sinc_cascade_decim_bench.sv
module sinc_cascade_decim_bench;
    localparam int IN_W  = 4;
    localparam int OUT_W = 24;
    localparam int MAXK  = 9;

    typedef longint lq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] rate_sel = '0;
    logic fam_sel = 1'b0;
    logic x_valid = 1'b0;
    logic signed [IN_W-1:0] x_data = '0;
    logic y_valid;
    logic signed [OUT_W-1:0] y_data;

    int n_checks = 0;
    int n_fail = 0;
    longint cyc = 0;
    bit cap_en = 1'b0;
    lq_t ys, yt, xs;

    sinc_cascade_decim u_sinc_cascade_decim (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
        .fam_sel(fam_sel), .x_valid(x_valid), .x_data(x_data),
        .y_valid(y_valid), .y_data(y_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (cap_en && y_valid) begin
            ys.push_back(longint'(y_data));
            yt.push_back(cyc);
        end
    end

    function automatic lq_t mov_sum(lq_t a, int len);
        lq_t r;
        longint acc = 0;
        foreach (a[i]) begin
            acc += a[i];
            if (i >= len) acc -= a[i-len];
            r.push_back(acc);
        end
        return r;
    endfunction

    function automatic lq_t pick(lq_t a, int step);
        lq_t r;
        for (int i = step - 1; i < a.size(); i += step) r.push_back(a[i]);
        return r;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0: constant, 1: impulse, 2: random
    task automatic run_case(string tag, bit do_start, bit fam, int code, int n,
                            int mode, int amp, int imp_pos, int vpct, bit wiggle,
                            bit chk_period);
        int k, r, d, i;
        longint g;
        lq_t s, e;
        ys.delete(); yt.delete(); xs.delete();
        @(negedge clk);
        fam_sel  = fam;
        rate_sel = 4'(code);
        if (do_start) begin
            start = 1'b1; x_valid = 1'b1; x_data = 4'sd7;   // R7: ignored sample
            @(negedge clk);
            start = 1'b0; x_valid = 1'b0;
        end
        cap_en = 1'b1;
        i = 0;
        while (i < n) begin
            if (wiggle && i == n / 2) begin
                rate_sel = 4'($urandom_range(15));
                fam_sel  = ~fam_sel;
            end
            if (int'($urandom_range(99)) < vpct) begin
                longint v;
                if (mode == 0) v = amp;
                else if (mode == 1) v = (i == imp_pos) ? amp : 0;
                else v = longint'($urandom_range(15)) - 8;
                x_valid = 1'b1;
                x_data  = IN_W'(v);
                xs.push_back(v);
                i++;
            end else begin
                x_valid = 1'b0;
                x_data  = IN_W'($urandom_range(15));   // R11: junk on idle cycles
            end
            @(negedge clk);
        end
        x_valid = 1'b0;
        repeat (6) @(negedge clk);
        cap_en = 1'b0;

        k = (code > MAXK) ? MAXK : code;
        r = fam ? 12 : 10;
        d = 1 << k;
        s = xs;
        repeat (5) s = mov_sum(s, r);
        s = pick(s, r);
        if (k == 0) begin
            if (s.size() > 4) e = s[4:$];
        end else begin
            repeat (3) s = mov_sum(s, d);
            s = pick(s, d);
            if (s.size() > 3) e = s[3:$];
            foreach (e[j]) e[j] = e[j] >>> (3 * k);
        end
        check("R8", {tag, " word count"}, ys.size(), e.size());
        g = longint'(r) ** 5;
        foreach (ys[j]) begin
            if (j < e.size()) begin
                if (mode == 0) check("R9", {tag, " constant level"}, ys[j], amp * g);
                else check(tag, "word value", ys[j], e[j]);
            end
        end
        if (chk_period) begin
            for (int j = 1; j < yt.size(); j++)
                check("R10", {tag, " word spacing"}, yt[j] - yt[j-1], longint'(r) * d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", longint'(y_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "valid after reset", longint'(y_valid), 0);
        // R1: no start yet, defaults are bypass and family 0
        run_case("R1", 1'b0, 1'b0, 0, 200, 0, 5, 0, 100, 1'b0, 1'b1);
        run_case("R3", 1'b1, 1'b0, 2, 500, 1, 7, 150, 100, 1'b0, 1'b0);
        run_case("R11", 1'b1, 1'b1, 3, 2000, 2, 0, 0, 60, 1'b0, 1'b0);
        run_case("R6", 1'b1, 1'b0, 1, 1500, 2, 0, 0, 100, 1'b1, 1'b1);
        run_case("R4", 1'b1, 1'b1, 0, 600, 2, 0, 0, 80, 1'b0, 1'b0);
        run_case("R2", 1'b1, 1'b1, 4, 1500, 2, 0, 0, 100, 1'b0, 1'b1);
        run_case("R9", 1'b1, 1'b0, 6, 4480, 0, -8, 0, 100, 1'b0, 1'b1);
        run_case("R5", 1'b1, 1'b1, 15, 36864, 0, -3, 0, 100, 1'b0, 1'b1);
        run_case("R7", 1'b1, 1'b0, 2, 800, 2, 0, 0, 100, 1'b1, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule